// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between a device's memory clients and the system bus. It turns a 32-bit device virtual address into a wider physical address by looking up one 32-bit entry in a single-level table held in memory. That table covers a 4 GB space of 4 KB pages, so it has 2^20 entries. Recent translations are kept in a small fully associative cache. An entry can mark a whole aligned 64 KB or 1 MB region, and one cached copy then serves every page of that region. On a miss the block issues exactly one read to memory and waits for the answer. It accepts no further request until that answer has arrived.

Every resolved access is checked for two faults: an entry that is not valid, and a write through an entry that is read-only. Software chooses, per fault type, whether the fault aborts the access and whether it raises the interrupt. A scratch frame can be enabled so that faulting accesses are steered there instead of aborting. Software can also order a full cache invalidation and watch a busy flag until it completes.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and irq are 0, and the control, fault-status and fault-address registers read 0.
- R2: While the enable bit (control bit 0) is 0, an accepted request gets rsp_valid one cycle later, with rsp_pa equal to the zero-extended virtual address, rsp_abort 0, and no table read.
- R3: When enabled, a miss issues one table read at {base_frame, 12'h000} + 4*VA[31:12]. The read address is held while pt_rd_ready is low. req_ready stays 0 until the response has been returned. rsp_pa is {entry[23:0], VA[11:0]}.
- R4: A later access that hits a cached entry needs no table read and gets rsp_valid one cycle after acceptance.
- R5: An entry with bit 30 set, and bit 31 clear, covers the aligned group of 16 pages around the page that loaded it. For a hit in that group, the low 4 frame bits are taken from VA[15:12].
- R6: An entry with bit 31 set covers an aligned group of 256 pages, and the low 8 frame bits are taken from VA[19:12].
- R7: There are 8 cache entries, filled round-robin from entry 0 after reset or invalidation. The 9th distinct fill evicts the 1st, and the 2nd stays cached.
- R8: An entry with bit 28 clear is an invalid fault. It sets fault-status bit 0. It aborts when control bit 1 is set. It raises irq while the status bit is set and control bit 2 is set. Such an entry is never cached.
- R9: A write through an entry with bit 29 clear is a write violation. It sets fault-status bit 1, aborts when control bit 3 is set, and interrupts when control bit 4 is set. A read through the same entry is not a fault.
- R10: When scratch-register bit 31 is set, a faulting access returns {scratch_frame, VA[11:0]} with rsp_abort 0, and it still sets the fault status.
- R11: Writing 1 to a fault-status bit clears it. The fault-address register holds the VA of the first fault taken while no status bit was set.
- R12: Writing control bit 8 invalidates all cache entries. Control bit 8 then reads 1 and req_ready is 0 until the invalidation is done. This takes one cycle when no miss is outstanding.

Register offsets on cfg_addr: 0 control, 1 table base frame, 2 scratch frame (bits 23:0) with enable (bit 31), 3 fault status, 4 fault address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_pa | output | 36 | Physical address |
| rsp_abort | output | 1 | Access aborted by a fault |
| pt_rd_valid | output | 1 | Table read request |
| pt_rd_ready | input | 1 | Memory takes the read |
| pt_rd_addr | output | 36 | Byte address of the table entry |
| pt_rsp_valid | input | 1 | Table entry returned |
| pt_rsp_data | input | 32 | Table entry |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Fault interrupt, level |

## Verification
A stale or corrupted cache entry shows at the ports in two ways. A table read appears where none was due, or goes missing where one was due, on the very access that should have hit or missed. The returned frame also differs in the same response, one cycle after acceptance. A wrong round-robin pointer or a wrong size mask shows only later, when an access that the model expects to hit fetches again, or returns a wrong low frame. For that reason the bench tracks read counts and addresses on every access. A wrong fault or status state shows on rsp_abort and irq in the same cycle as the response.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
   localparam int PTE_SUPER_BIT = 31;
   localparam int PTE_BIG_BIT   = 30;
   localparam int PTE_WR_BIT    = 29;
   localparam int PTE_VLD_BIT   = 28;

   localparam logic [2:0] RA_CTRL    = 3'd0;
   localparam logic [2:0] RA_BASE    = 3'd1;
   localparam logic [2:0] RA_SCRATCH = 3'd2;
   localparam logic [2:0] RA_FSTAT   = 3'd3;
   localparam logic [2:0] RA_FVA     = 3'd4;

   localparam int CTRL_CLR_BIT = 8;

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} walk_st_e;
   typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_BIG = 2'd1, SZ_SUPER = 2'd2} pg_size_e;
endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb import mmu_pkg::*; #(
   parameter int DEPTH      = 8,
   parameter int VPN_W      = 20,
   parameter int PFN_W      = 24,
   parameter int BIG_BITS   = 4,
   parameter int SUPER_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_wr,
   input  logic             ins_en,
   input  logic [VPN_W-1:0] ins_vpn,
   input  logic [PFN_W-1:0] ins_pfn,
   input  logic             ins_wr,
   input  pg_size_e         ins_size
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [DEPTH-1:0]            hit_vec;
   logic [DEPTH-1:0]            wr_vec;
   logic [DEPTH-1:0][PFN_W-1:0] mrg_vec;
   logic [IDX_W-1:0]            rr_ptr;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic                  v_q;
      logic [VPN_W-1:0]      tag_q;
      logic [PFN_W-1:0]      pfn_q;
      logic                  wr_q;
      pg_size_e              sz_q;
      logic [SUPER_BITS-1:0] lm;
      logic                  sel;

      assign sel = ins_en && (rr_ptr == IDX_W'(i));

      always_comb begin
         unique case (sz_q)
            SZ_BIG:   lm = SUPER_BITS'((1 << BIG_BITS) - 1);
            SZ_SUPER: lm = '1;
            default:  lm = '0;
         endcase
      end

      assign hit_vec[i] = v_q &&
         (((tag_q ^ lk_vpn) & {{(VPN_W-SUPER_BITS){1'b1}}, ~lm}) == '0);
      assign mrg_vec[i] = {pfn_q[PFN_W-1:SUPER_BITS],
                           (pfn_q[SUPER_BITS-1:0] & ~lm) | (lk_vpn[SUPER_BITS-1:0] & lm)};
      assign wr_vec[i]  = wr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     v_q <= 1'b0;
         else if (flush) v_q <= 1'b0;
         else if (sel)   v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q <= ins_vpn;
            pfn_q <= ins_pfn;
            wr_q  <= ins_wr;
            sz_q  <= ins_size;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rr_ptr <= '0;
      else if (flush)  rr_ptr <= '0;
      else if (ins_en) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
   end

   always_comb begin
      lk_hit = |hit_vec;
      lk_pfn = '0;
      lk_wr  = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            lk_pfn = mrg_vec[i];
            lk_wr  = wr_vec[i];
         end
      end
   end
endmodule

// File: rtl/mmu_regs.sv
module mmu_regs import mmu_pkg::*; #(
   parameter int VA_W  = 32,
   parameter int PFN_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic             clr_busy,
   output logic             clr_cmd,
   output logic             mmu_en,
   output logic             inv_abt_en,
   output logic             wv_abt_en,
   output logic [PFN_W-1:0] base_pfn,
   output logic             scr_en,
   output logic [PFN_W-1:0] scr_pfn,
   input  logic             set_inv,
   input  logic             set_wv,
   input  logic [VA_W-1:0]  fault_va,
   output logic [1:0]       fstat,
   output logic             irq
);
   logic [4:0]      ctrl_q;
   logic [VA_W-1:0] fva_q;
   logic [1:0]      fs_kept;
   logic            unused_wdata;

   assign mmu_en     = ctrl_q[0];
   assign inv_abt_en = ctrl_q[1];
   assign wv_abt_en  = ctrl_q[3];
   assign clr_cmd    = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[CTRL_CLR_BIT];
   assign irq        = (fstat[0] && ctrl_q[2]) || (fstat[1] && ctrl_q[4]);
   assign fs_kept    = (cfg_we && cfg_addr == RA_FSTAT) ? (fstat & ~cfg_wdata[1:0]) : fstat;
   assign unused_wdata = ^{cfg_wdata[30:PFN_W], cfg_wdata[7:5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         base_pfn <= '0;
         scr_en   <= 1'b0;
         scr_pfn  <= '0;
         fstat    <= '0;
         fva_q    <= '0;
      end else begin
         if (cfg_we) begin
            unique case (cfg_addr)
               RA_CTRL: ctrl_q   <= cfg_wdata[4:0];
               RA_BASE: base_pfn <= cfg_wdata[PFN_W-1:0];
               RA_SCRATCH: begin
                  scr_pfn <= cfg_wdata[PFN_W-1:0];
                  scr_en  <= cfg_wdata[31];
               end
               default: ;
            endcase
         end
         fstat <= fs_kept | {set_wv, set_inv};
         if ((set_inv || set_wv) && fs_kept == 2'b00) fva_q <= fault_va;
      end
   end

   always_comb begin
      unique case (cfg_addr)
         RA_CTRL:    cfg_rdata = {23'd0, clr_busy, 3'd0, ctrl_q};
         RA_BASE:    cfg_rdata = 32'(base_pfn);
         RA_SCRATCH: cfg_rdata = {scr_en, (31-PFN_W)'(0), scr_pfn};
         RA_FSTAT:   cfg_rdata = {30'd0, fstat};
         RA_FVA:     cfg_rdata = 32'(fva_q);
         default:    cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mmu_fault.sv
module mmu_fault #(
   parameter int PFN_W = 24
) (
   input  logic             pte_vld,
   input  logic             pte_wr,
   input  logic             is_write,
   input  logic             inv_abt_en,
   input  logic             wv_abt_en,
   input  logic             scr_en,
   input  logic [PFN_W-1:0] scr_pfn,
   input  logic [PFN_W-1:0] xl_pfn,
   output logic             f_inv,
   output logic             f_wv,
   output logic             abort,
   output logic [PFN_W-1:0] out_pfn
);
   assign f_inv   = !pte_vld;
   assign f_wv    = pte_vld && is_write && !pte_wr;
   assign abort   = !scr_en && ((f_inv && inv_abt_en) || (f_wv && wv_abt_en));
   assign out_pfn = (scr_en && (f_inv || f_wv)) ? scr_pfn : xl_pfn;
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate import mmu_pkg::*; #(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int PFN_W      = 24,
   parameter int TLB_DEPTH  = 8,
   parameter int BIG_BITS   = 4,
   parameter int SUPER_BITS = 8,
   localparam int VPN_W     = VA_W - PAGE_SHIFT,
   localparam int PA_W      = PFN_W + PAGE_SHIFT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   input  logic            req_write,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_pa,
   output logic            rsp_abort,
   output logic            pt_rd_valid,
   input  logic            pt_rd_ready,
   output logic [PA_W-1:0] pt_rd_addr,
   input  logic            pt_rsp_valid,
   input  logic [31:0]     pt_rsp_data,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   output logic            irq
);
   if (VA_W > 32 || PA_W < VA_W) begin : g_bad_width
      $error("mmu_xlate: address widths out of range");
   end
   if (PFN_W > PTE_VLD_BIT) begin : g_bad_pfn
      $error("mmu_xlate: frame field overlaps entry flags");
   end
   if (BIG_BITS >= SUPER_BITS || SUPER_BITS > VPN_W || SUPER_BITS > PFN_W) begin : g_bad_size
      $error("mmu_xlate: region size parameters inconsistent");
   end
   if (TLB_DEPTH < 1) begin : g_bad_depth
      $error("mmu_xlate: cache depth must be at least one");
   end

   walk_st_e          state;
   logic [VA_W-1:0]   hold_va;
   logic              hold_wr;
   logic              clr_pend;
   logic              clr_cmd;
   logic              mmu_en, inv_abt_en, wv_abt_en, scr_en;
   logic [PFN_W-1:0]  base_pfn, scr_pfn;
   logic [1:0]        fstat;
   logic              accept, fetch_done, tlb_res, resolve, pass, flush, ins_en;
   logic              lk_hit, lk_wr;
   logic [PFN_W-1:0]  lk_pfn;
   pg_size_e          f_size;
   logic [SUPER_BITS-1:0] f_lm;
   logic [PFN_W-1:0]  f_pfn, xl_pfn, out_pfn;
   logic              pte_vld, pte_wr, cur_wr;
   logic [VA_W-1:0]   cur_va;
   logic              f_inv, f_wv, f_abort, set_inv, set_wv;
   logic              unused_data;

   assign req_ready  = (state == ST_IDLE) && !clr_pend;
   assign accept     = req_valid && req_ready;
   assign pass       = accept && !mmu_en;
   assign tlb_res    = accept && mmu_en && lk_hit;
   assign fetch_done = (state == ST_WAIT) && pt_rsp_valid;
   assign resolve    = tlb_res || fetch_done;
   assign flush      = clr_pend && (state == ST_IDLE);
   assign ins_en     = fetch_done && pt_rsp_data[PTE_VLD_BIT];
   assign unused_data = ^pt_rsp_data[27:PFN_W];

   always_comb begin
      if (pt_rsp_data[PTE_SUPER_BIT])    f_size = SZ_SUPER;
      else if (pt_rsp_data[PTE_BIG_BIT]) f_size = SZ_BIG;
      else                               f_size = SZ_4K;
      unique case (f_size)
         SZ_BIG:   f_lm = SUPER_BITS'((1 << BIG_BITS) - 1);
         SZ_SUPER: f_lm = '1;
         default:  f_lm = '0;
      endcase
   end

   assign f_pfn  = {pt_rsp_data[PFN_W-1:SUPER_BITS],
                    (pt_rsp_data[SUPER_BITS-1:0] & ~f_lm) |
                    (hold_va[PAGE_SHIFT +: SUPER_BITS] & f_lm)};
   assign pte_vld = fetch_done ? pt_rsp_data[PTE_VLD_BIT] : 1'b1;
   assign pte_wr  = fetch_done ? pt_rsp_data[PTE_WR_BIT]  : lk_wr;
   assign xl_pfn  = fetch_done ? f_pfn   : lk_pfn;
   assign cur_va  = fetch_done ? hold_va : req_va;
   assign cur_wr  = fetch_done ? hold_wr : req_write;
   assign set_inv = resolve && f_inv;
   assign set_wv  = resolve && f_wv;

   assign pt_rd_valid = (state == ST_REQ);
   assign pt_rd_addr  = {base_pfn, PAGE_SHIFT'(0)} + PA_W'({hold_va[VA_W-1:PAGE_SHIFT], 2'b00});

   mmu_tlb #(
      .DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W),
      .BIG_BITS(BIG_BITS), .SUPER_BITS(SUPER_BITS)
   ) u_tlb (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_vpn(req_va[VA_W-1:PAGE_SHIFT]), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr(lk_wr),
      .ins_en(ins_en), .ins_vpn(hold_va[VA_W-1:PAGE_SHIFT]),
      .ins_pfn(pt_rsp_data[PFN_W-1:0]), .ins_wr(pt_rsp_data[PTE_WR_BIT]), .ins_size(f_size)
   );

   mmu_regs #(.VA_W(VA_W), .PFN_W(PFN_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .clr_busy(clr_pend), .clr_cmd(clr_cmd),
      .mmu_en(mmu_en), .inv_abt_en(inv_abt_en), .wv_abt_en(wv_abt_en),
      .base_pfn(base_pfn), .scr_en(scr_en), .scr_pfn(scr_pfn),
      .set_inv(set_inv), .set_wv(set_wv), .fault_va(cur_va),
      .fstat(fstat), .irq(irq)
   );

   mmu_fault #(.PFN_W(PFN_W)) u_fault (
      .pte_vld(pte_vld), .pte_wr(pte_wr), .is_write(cur_wr),
      .inv_abt_en(inv_abt_en), .wv_abt_en(wv_abt_en),
      .scr_en(scr_en), .scr_pfn(scr_pfn), .xl_pfn(xl_pfn),
      .f_inv(f_inv), .f_wv(f_wv), .abort(f_abort), .out_pfn(out_pfn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hold_va  <= '0;
         hold_wr  <= 1'b0;
         clr_pend <= 1'b0;
      end else begin
         if (clr_cmd)    clr_pend <= 1'b1;
         else if (flush) clr_pend <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept && mmu_en && !lk_hit) begin
               hold_va <= req_va;
               hold_wr <= req_write;
               state   <= ST_REQ;
            end
            ST_REQ:  if (pt_rd_ready)  state <= ST_WAIT;
            ST_WAIT: if (pt_rsp_valid) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_abort <= 1'b0;
      end else begin
         rsp_valid <= resolve || pass;
         rsp_abort <= resolve && f_abort;
         if (pass)         rsp_pa <= PA_W'(req_va);
         else if (resolve) rsp_pa <= {out_pfn, cur_va[PAGE_SHIFT-1:0]};
      end
   end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk import mmu_pkg::*; #(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_va,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_pa,
   input logic            rsp_abort,
   input logic            pt_rd_valid,
   input logic            pt_rd_ready,
   input logic [PA_W-1:0] pt_rd_addr,
   input logic            irq,
   input logic            mmu_en,
   input logic            clr_pend,
   input logic            scr_en,
   input logic [1:0]      fstat,
   input walk_st_e        state
);
   p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pt_rd_valid && !pt_rd_ready |=> pt_rd_valid && $stable(pt_rd_addr));

   p_single_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pt_rd_valid |-> !req_ready);

   p_pass_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !mmu_en |=>
         rsp_valid && !rsp_abort && rsp_pa == PA_W'($past(req_va)));

   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> fstat != 2'b00);

   p_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(scr_en) |-> !rsp_abort);

   p_clear_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend |-> !req_ready);

   p_clear_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend && state == ST_IDLE |=> !clr_pend);
endmodule

bind mmu_xlate mmu_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
   .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_abort(rsp_abort),
   .pt_rd_valid(pt_rd_valid), .pt_rd_ready(pt_rd_ready), .pt_rd_addr(pt_rd_addr),
   .irq(irq), .mmu_en(mmu_en), .clr_pend(clr_pend), .scr_en(scr_en),
   .fstat(fstat), .state(state)
);

// File: tb/mmu_xlate_tb.sv
module mmu_xlate_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready, rsp_valid, rsp_abort, pt_rd_valid, irq;
   logic [35:0] rsp_pa, pt_rd_addr;
   logic        pt_rd_ready = 1'b0, pt_rsp_valid = 1'b0;
   logic [31:0] pt_rsp_data = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
      .rsp_abort(rsp_abort), .pt_rd_valid(pt_rd_valid), .pt_rd_ready(pt_rd_ready),
      .pt_rd_addr(pt_rd_addr), .pt_rsp_valid(pt_rsp_valid), .pt_rsp_data(pt_rsp_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq(irq)
   );

   int n_chk = 0, n_fail = 0, owed = 0, fetch_cnt = 0;
   bit done = 0;
   logic [35:0] last_fetch = '0;
   logic [31:0] ptm [int];

   // reference state
   logic [4:0]  m_ctrl = '0;
   logic [23:0] m_base = '0, m_scr = '0;
   bit          m_scr_en = 0;
   logic [1:0]  m_fs = '0;
   logic [31:0] m_fva = '0;
   logic [31:0] mt_pte [8];
   logic [19:0] mt_vpn [8];
   bit          mt_v [8];
   int          mt_ptr = 0;

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 3'd0) begin
         m_ctrl = d[4:0];
         if (d[8]) begin
            for (int i = 0; i < 8; i++) mt_v[i] = 0;
            mt_ptr = 0;
         end
      end
      if (a == 3'd1) m_base = d[23:0];
      if (a == 3'd2) begin m_scr = d[23:0]; m_scr_en = d[31]; end
      if (a == 3'd3) m_fs = m_fs & ~d[1:0];
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   function automatic logic [23:0] low_mask(input logic [31:0] pte);
      return pte[31] ? 24'hFF : (pte[30] ? 24'hF : 24'h0);
   endfunction

   function automatic bit m_irq();
      return (m_fs[0] && m_ctrl[2]) || (m_fs[1] && m_ctrl[4]);
   endfunction

   // translate one address and compare against the reference
   task automatic xlate(input logic [31:0] va, input bit wrt, input string rq);
      logic [19:0] vpn = va[31:12];
      logic [31:0] pte;
      logic [23:0] pfn;
      logic [35:0] exp_pa;
      bit miss = 0, inv, wv, ab;
      int hit = -1, lat = 0, f0 = fetch_cnt;
      if (!m_ctrl[0]) begin
         exp_pa = {4'h0, va}; ab = 0;
      end else begin
         for (int i = 7; i >= 0; i--)
            if (mt_v[i] && (((mt_vpn[i] ^ vpn) & ~low_mask(mt_pte[i])[19:0]) == 20'h0)) hit = i;
         if (hit >= 0) pte = mt_pte[hit];
         else begin
            miss = 1;
            pte = ptm.exists(int'(vpn)) ? ptm[int'(vpn)] : 32'h0;
         end
         pfn = (pte[23:0] & ~low_mask(pte)) | ({4'h0, vpn} & low_mask(pte));
         inv = !pte[28];
         wv  = !inv && wrt && !pte[29];
         ab  = !m_scr_en && ((inv && m_ctrl[1]) || (wv && m_ctrl[3]));
         if (m_scr_en && (inv || wv)) pfn = m_scr;
         exp_pa = {pfn, va[11:0]};
         if (miss && pte[28]) begin
            mt_pte[mt_ptr] = pte; mt_vpn[mt_ptr] = vpn; mt_v[mt_ptr] = 1;
            mt_ptr = (mt_ptr + 1) % 8;
         end
         if ((inv || wv) && m_fs == 2'b00) m_fva = va;
         m_fs = m_fs | {wv, inv};
      end
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = wrt;
      while (!req_ready) @(negedge clk);
      owed++;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      if (miss) chk(rq, "req_ready low during miss", {63'h0, req_ready}, 64'h0);
      while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
      chk(rq, "rsp_valid", {63'h0, rsp_valid}, 64'h1);
      chk(rq, "latency", 64'(lat), miss ? 64'd3 : 64'd1);
      chk(rq, "rsp_pa", {28'h0, rsp_pa}, {28'h0, exp_pa});
      chk(rq, "rsp_abort", {63'h0, rsp_abort}, {63'h0, ab});
      chk(rq, "table reads", 64'(fetch_cnt - f0), miss ? 64'd1 : 64'd0);
      if (miss)
         chk(rq, "read address", {28'h0, last_fetch}, {28'h0, {m_base, 12'h000} + {14'h0, vpn, 2'b00}});
      chk(rq, "irq", {63'h0, irq}, {63'h0, m_irq()});
   endtask

   // memory behind the fetch port: one stall cycle, then answer
   initial begin
      bit pend = 0;
      forever begin
         @(negedge clk);
         pt_rsp_valid = 1'b0;
         if (pend) begin
            pt_rd_ready = 1'b0;
            pt_rsp_valid = 1'b1;
            pt_rsp_data = ptm.exists(int'((last_fetch - {m_base, 12'h000}) >> 2)) ?
                          ptm[int'((last_fetch - {m_base, 12'h000}) >> 2)] : 32'h0;
            pend = 0;
         end else if (pt_rd_valid) begin
            pt_rd_ready = 1'b1;
            last_fetch = pt_rd_addr;
            fetch_cnt++;
            pend = 1;
         end
      end
   end

   // every clock: a response must be owed
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && rsp_valid) begin
            n_chk++;
            if (owed == 0) begin
               n_fail++;
               $display("FAIL R4 unexpected response: actual rsp_valid 1 expected 0");
            end else owed--;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 8; i++) mt_v[i] = 0;
      ptm[32'h10]  = 32'h3000_0000 | 32'h0ABCDE;
      ptm[32'h23]  = 32'h7000_0000 | 32'h000403;
      ptm[32'h305] = 32'hB000_0000 | 32'h012305;
      for (int i = 0; i < 8; i++) ptm[32'h40 + i] = 32'h3000_0000 | (32'h000900 + i);
      ptm[32'h600] = 32'h1000_0000 | 32'h000777;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1", "req_ready", {63'h0, req_ready}, 64'h1);
      chk("R1", "rsp_valid", {63'h0, rsp_valid}, 64'h0);
      chk("R1", "irq", {63'h0, irq}, 64'h0);
      rd(3'd0, d); chk("R1", "control", {32'h0, d}, 64'h0);
      rd(3'd3, d); chk("R1", "fault status", {32'h0, d}, 64'h0);
      rd(3'd4, d); chk("R1", "fault address", {32'h0, d}, 64'h0);

      xlate(32'h1234_5678, 0, "R2");
      xlate(32'hFFFF_F001, 1, "R2");

      wr(3'd1, 32'h0000_0100);
      wr(3'd0, 32'h0000_001F);
      xlate(32'h0001_0123, 0, "R3");
      xlate(32'h0001_0FFC, 1, "R4");
      xlate(32'h0002_3010, 0, "R5");
      xlate(32'h0002_A444, 1, "R5");
      xlate(32'h0030_5008, 0, "R6");
      xlate(32'h003C_7EEE, 0, "R6");

      // R12 invalidation
      wr(3'd0, 32'h0000_011F);
      rd(3'd0, d);
      chk("R12", "busy bit", {63'h0, d[8]}, 64'h1);
      chk("R12", "req_ready while busy", {63'h0, req_ready}, 64'h0);
      @(negedge clk);
      rd(3'd0, d);
      chk("R12", "busy bit after", {63'h0, d[8]}, 64'h0);
      chk("R12", "req_ready after", {63'h0, req_ready}, 64'h1);
      xlate(32'h0001_0200, 0, "R12");

      // R7 round robin
      for (int i = 0; i < 8; i++) xlate(32'h0004_0000 + (i << 12), 0, "R7");
      xlate(32'h0004_0010, 0, "R7");
      xlate(32'h0001_0300, 0, "R7");

      // R8 invalid entries, R11 first address kept
      xlate(32'h0050_0123, 0, "R8");
      rd(3'd3, d); chk("R8", "status", {32'h0, d}, 64'h1);
      xlate(32'h0050_0ABC, 1, "R8");
      rd(3'd4, d); chk("R11", "fault address", {32'h0, d}, 64'h0050_0123);
      wr(3'd3, 32'h1);
      rd(3'd3, d); chk("R11", "status cleared", {32'h0, d}, 64'h0);
      chk("R11", "irq cleared", {63'h0, irq}, 64'h0);

      // R9
      xlate(32'h0060_0040, 0, "R9");
      xlate(32'h0060_0044, 1, "R9");
      rd(3'd3, d); chk("R9", "status", {32'h0, d}, 64'h2);
      wr(3'd3, 32'h3);

      // R8 with aborts only
      wr(3'd0, 32'h0000_000B);
      xlate(32'h0070_0001, 0, "R8");
      wr(3'd3, 32'h3);

      // R10 scratch redirect
      wr(3'd0, 32'h0000_001F);
      wr(3'd2, 32'h800F_FFFF);
      xlate(32'h0050_0ABC, 0, "R10");
      rd(3'd3, d); chk("R10", "status", {32'h0, d}, 64'h1);
      wr(3'd3, 32'h1);
      xlate(32'h0060_0F00, 1, "R10");
      wr(3'd3, 32'h3);

      repeat (3) @(negedge clk);
      done = 1;
      summary();
   end
endmodule